// File: doc/BRIEF.md
# Conversion Completion Flag and Result Slot Tracker

This block sits beside a sequencing analog-to-digital converter and records how each conversion of a sequence ended. A sequence has up to ten conversions. Each conversion is identified by its position in the sequence, not by the input channel it sampled. Position n owns result slot n and completion flag n. When a conversion finishes, the converter sends a one-cycle done pulse. The pulse carries the position and the 12-bit result.

Each slot has a compare-enable bit and an operator bit. With compare disabled, the result is written into the slot and the flag is raised. With compare enabled, the slot holds a threshold that software loaded. The new result is tested against that threshold and then discarded. The flag rises only when the test passes. A compare interrupt reports any passed comparison while its enable is set.

Flags can be cleared in four ways:
- a sequence-start strobe clears all flags;
- with fast-clear off, a write-one to the flag register clears the flags written;
- with fast-clear on and compare off, reading a slot clears its flag;
- with fast-clear on and compare on, writing a slot clears its flag.

Top module: `adc_flag_tracker`

## Requirements
- R1: After reset, all flags read 0, all result slots read 0 and `cmp_irq` is 0.
- R2: A done pulse for position n below 10, with `cmp_en[n]`=0, stores `done_res` in slot n. The slot reads back at address n, zero-extended. The same pulse sets flag n, which is bit n of `flags` and bit n of the word at address 10. The stored value is visible in the cycle after the pulse.
- R3: A done pulse for position n with `cmp_en[n]`=1 leaves slot n unchanged. It sets flag n only if the comparison holds. With `cmp_gt[n]`=1 the comparison is result > slot value. With `cmp_gt[n]`=0 it is result <= slot value.
- R4: `cmp_irq` is 1 exactly when `cmp_ie` is 1 and at least one flag of a compare-enabled slot is set. It drops once those flags are cleared.
- R5: `seq_start` clears every flag. A done pulse in the same cycle does not set its flag.
- R6: With `fast_clr`=0, writing address 10 clears each flag whose `wdata` bit is 1. Bits written as 0 have no effect. A flag set by a done pulse in the same cycle stays set.
- R7: With `fast_clr`=1 and `cmp_en[n]`=0, a read of address n (`rd_en`=1) clears flag n. A set in the same cycle wins.
- R8: With `fast_clr`=1 and `cmp_en[n]`=1, a write to address n loads slot n and clears flag n. A set in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| done | input | 1 | Conversion finished, one cycle |
| done_pos | input | 4 | Position of the finished conversion in its sequence |
| done_res | input | 12 | Conversion result |
| cmp_en | input | 10 | Per-slot compare enable |
| cmp_gt | input | 10 | Per-slot operator: 1 greater-than, 0 less-or-equal |
| seq_start | input | 1 | New sequence started, one cycle |
| fast_clr | input | 1 | Selects access-based flag clearing |
| cmp_ie | input | 1 | Compare interrupt enable |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | 4 | 0-9 slots, 10 flag register |
| wdata | input | 16 | Bus write data |
| rdata | output | 16 | Bus read data for `addr` |
| flags | output | 10 | Completion flags |
| cmp_irq | output | 1 | Compare interrupt |

## Verification
The hazard is a flag being set and cleared in the same cycle. The bench drives a done pulse for a position in the same cycle as each of the four clear paths aimed at that position: sequence start, write-one, slot read and slot write. It then checks the flag one cycle later. Only the sequence start may leave the flag at 0; the other three must leave it at 1.

// File: rtl/adc_flag_tracker.sv
module adc_flag_tracker #(
  parameter int NSLOT = 10,
  parameter int RW    = 12,
  parameter int DW    = 16,
  localparam int PW   = $clog2(NSLOT),
  localparam int AW   = $clog2(NSLOT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done,
  input  logic [PW-1:0]    done_pos,
  input  logic [RW-1:0]    done_res,
  input  logic [NSLOT-1:0] cmp_en,
  input  logic [NSLOT-1:0] cmp_gt,
  input  logic             seq_start,
  input  logic             fast_clr,
  input  logic             cmp_ie,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic [NSLOT-1:0] flags,
  output logic             cmp_irq
);

  logic [RW-1:0]    slot [NSLOT];
  logic [NSLOT-1:0] set_v, clr_v;
  logic [RW-1:0]    thr;
  logic             pos_ok, pass;

  assign pos_ok = 32'(done_pos) < NSLOT;
  assign thr    = pos_ok ? slot[done_pos] : '0;

  always_comb begin
    pass = 1'b0;
    if (pos_ok) pass = cmp_gt[done_pos] ? (done_res > thr) : (done_res <= thr);
  end

  always_comb begin
    for (int i = 0; i < NSLOT; i++) begin
      set_v[i] = done && done_pos == PW'(i) && (!cmp_en[i] || pass);
      clr_v[i] = (wr_en && addr == AW'(NSLOT) && !fast_clr && wdata[i])
              || (fast_clr && !cmp_en[i] && rd_en && addr == AW'(i))
              || (fast_clr &&  cmp_en[i] && wr_en && addr == AW'(i));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         flags <= '0;
    else if (seq_start) flags <= '0;
    else                flags <= (flags & ~clr_v) | set_v;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NSLOT; i++) begin
      if (!rst_n) slot[i] <= '0;
      else if (done && done_pos == PW'(i) && !cmp_en[i]) slot[i] <= done_res;
      else if (wr_en && addr == AW'(i)) slot[i] <= wdata[RW-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (32'(addr) < NSLOT)   rdata = DW'(slot[addr]);
    else if (addr == AW'(NSLOT)) rdata = DW'(flags);
  end

  assign cmp_irq = cmp_ie && |(flags & cmp_en);

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |=> flags == '0); // R5

  AST_STORE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && pos_ok && !cmp_en[done_pos] && !seq_start)
      |=> flags[$past(done_pos)] && slot[$past(done_pos)] == $past(done_res)); // R2

  AST_CMP_KEEPS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && pos_ok && cmp_en[done_pos] && !wr_en)
      |=> slot[$past(done_pos)] == $past(thr)); // R3

  AST_NO_SET_WITHOUT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> (flags & ~$past(flags)) == '0); // R6

  AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_ie |-> !cmp_irq); // R4

endmodule

// File: tb/tb_adc_flag_tracker.sv
module tb_adc_flag_tracker;
  logic clk = 0, rst_n = 0;
  logic done = 0, seq_start = 0, fast_clr = 0, cmp_ie = 0, wr_en = 0, rd_en = 0;
  logic [3:0] done_pos = 0, addr = 0;
  logic [11:0] done_res = 0;
  logic [9:0] cmp_en = 0, cmp_gt = 0;
  logic [15:0] wdata = 0;
  logic [15:0] rdata;
  logic [9:0] flags;
  logic cmp_irq;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  adc_flag_tracker dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    done = 0; seq_start = 0; wr_en = 0; rd_en = 0;
  endtask

  task automatic conv(int p, int r);
    done = 1; done_pos = 4'(p); done_res = 12'(r); tick();
  endtask

  task automatic bus_wr(int a, int d);
    wr_en = 1; addr = 4'(a); wdata = 16'(d); tick();
  endtask

  task automatic t_reset();
    addr = 10; #1; chk("R1 flags", flags, 0); chk("R1 irq", cmp_irq, 0);
    chk("R1 flagreg", rdata, 0);
    addr = 3; #1; chk("R1 slot3", rdata, 0);
  endtask

  task automatic t_store();
    conv(2, 12'hABC);
    chk("R2 flag2", flags, 10'h004);
    addr = 2; #1; chk("R2 slot2", rdata, 16'h0ABC);
    addr = 10; #1; chk("R2 flagreg", rdata, 16'h0004);
  endtask

  task automatic t_w1c();
    bus_wr(10, 0);
    chk("R6 write0 no effect", flags, 10'h004);
    bus_wr(10, 16'h0004);
    chk("R6 write1 clears", flags, 0);
    done = 1; done_pos = 5; done_res = 1; bus_wr(10, 16'h0020);
    chk("R6 set wins", flags, 10'h020);
    bus_wr(10, 16'h03FF);
  endtask

  task automatic t_start();
    conv(1, 5); conv(3, 6);
    chk("R2 two flags", flags, 10'h00A);
    seq_start = 1; tick();
    chk("R5 start clears", flags, 0);
    seq_start = 1; done = 1; done_pos = 4; done_res = 7; tick();
    chk("R5 start beats set", flags, 0);
    addr = 4; #1; chk("R2 slot4 stored", rdata, 7);
  endtask

  task automatic t_compare();
    fast_clr = 1; cmp_en = 10'h0C0; cmp_gt = 10'h040; cmp_ie = 1;
    bus_wr(6, 16'h0100); bus_wr(7, 16'h0200);
    conv(6, 12'h100);
    chk("R3 gt equal fails", flags, 0);
    conv(6, 12'h101);
    chk("R3 gt passes", flags, 10'h040);
    addr = 6; #1; chk("R3 slot6 kept", rdata, 16'h0100);
    chk("R4 irq on", cmp_irq, 1);
    cmp_ie = 0; #1; chk("R4 irq masked", cmp_irq, 0); cmp_ie = 1;
    bus_wr(6, 16'h0100);
    chk("R8 write clears", flags, 0);
    chk("R4 irq drops", cmp_irq, 0);
    conv(7, 12'h201);
    chk("R3 le fails", flags, 0);
    conv(7, 12'h200);
    chk("R3 le equal passes", flags, 10'h080);
    addr = 7; #1; chk("R3 slot7 kept", rdata, 16'h0200);
    rd_en = 1; addr = 7; tick();
    chk("R8 read no clear", flags, 10'h080);
    bus_wr(7, 16'h0200);
    done = 1; done_pos = 6; done_res = 12'hFFF; bus_wr(6, 16'h0100);
    chk("R8 set wins", flags, 10'h040);
    bus_wr(6, 16'h0100);
  endtask

  task automatic t_rdclr();
    conv(2, 12'h123);
    chk("R2 flag2 again", flags, 10'h004);
    chk("R4 no irq for plain slot", cmp_irq, 0);
    rd_en = 1; addr = 2; tick();
    chk("R7 read clears", flags, 0);
    conv(2, 12'h124);
    bus_wr(10, 16'h0004);
    chk("R6 w1c off in fast mode", flags, 10'h004);
    rd_en = 1; addr = 2; tick();
    done = 1; done_pos = 2; done_res = 9; rd_en = 1; addr = 2; tick();
    chk("R7 set wins", flags, 10'h004);
  endtask

  initial begin
    #600000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset(); t_store(); t_w1c(); t_start(); t_compare(); t_rdclr();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule